// File: doc/BRIEF.md
# Cellular Network Node Compute Core

This block is the arithmetic heart of one node in a grid of cellular-network cells. The router delivers a serial stream of neighbour values, and each value carries a small tag that says which neighbour it came from. For every accepted value the core reads a weight from a local template memory, multiplies the two and adds the product into an accumulator. The template memory also holds the discrimination table, which maps the node's state to its output.

A run begins with a start pulse. The start pulse latches the template base (which template to use) and the number of feedback iterations. The first pass takes nine input values. The core weights them with the control coefficients, adds the bias, and keeps the result as a constant. Each later pass takes nine neighbour outputs, weights them with the feedback coefficients and adds that sum to the stored constant. The result is then discriminated through the table into the output register. A done flag follows the last discrimination. Templates and table entries are written through a plain write port, which is the landing point of the transport path.

Top module: `cnn_node_core`

## Requirements
- R1: After reset, `y_out` is 0 and `done` and `in_ready` are both low.
- R2: A coefficient is read from word address base*32 + flag*16 + index. The flag is 0 in the input pass and 1 in a feedback pass. The index is the pair's tag (0..8) or 9 for the bias, which is read with the flag at 0.
- R3: In the input pass, `in_ready` is high and exactly nine valid pairs are taken. The constant is the sum of value times control coefficient, plus the bias.
- R4: Every feedback pass takes nine pairs and forms state = constant + sum of value times feedback coefficient. The constant is formed once per run and is never rebuilt between iterations.
- R5: Discrimination loads `y_out` with the table word at address 63*32 + (s + 16), where s is the state arithmetically shifted right by 2 and clamped to -16..15. `y_out` changes at no other time.
- R6: The iteration count is latched at start. The core runs exactly that many feedback passes. A count of 0 discriminates the constant itself. `done` rises after the last discrimination, stays high, and clears on the next accepted start.
- R7: A pair whose tag is 9..15 is accepted but ignored. It is neither counted nor accumulated.
- R8: A start pulse while a run is in progress has no effect on the run.
- R9: A template write may occur in any cycle. If it targets the coefficient being read in that same cycle, the old coefficient is used. Later reads see the new one.
- R10: States above or below the table range give the top (index 31) or bottom (index 0) table word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken only when idle) |
| tpl_base | input | 6 | Template base latched at start |
| n_iter | input | 8 | Feedback iteration count latched at start |
| in_valid | input | 1 | A value/tag pair is present |
| in_data | input | 8 | Signed neighbour value |
| in_tag | input | 4 | Neighbour tag (0..8 valid) |
| in_ready | output | 1 | Core is in a pass and accepts pairs |
| wr_en | input | 1 | Template memory write strobe |
| wr_addr | input | 11 | Template memory word address |
| wr_data | input | 8 | Template memory write data |
| y_out | output | 8 | Node output register |
| done | output | 1 | Run finished |

## Verification
Two of the block's functions can meet in one cycle. A template write may land on the very coefficient slot that the multiply-accumulate is reading for the pair being accepted. The bench provokes this by issuing a write to that slot's address at the same clock edge on which the pair is taken. The result is judged correct only if it uses the old coefficient, and the next run on that template must then produce a result built from the new one. A start pulse placed in the middle of a pass is the second overlap. The bench drives one with a different base and expects a result computed from the original template.

// File: rtl/cnn_node_pkg.sv
package cnn_node_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_UPASS = 3'd1,
        PH_BIAS  = 3'd2,
        PH_YPASS = 3'd3,
        PH_DISC  = 3'd4
    } phase_e;

endpackage

// File: rtl/cnn_coef_addr.sv
module cnn_coef_addr #(
    parameter int BASE_W = 6,
    parameter int IDX_W  = 4,
    parameter int NEIGH  = 9,
    localparam int AW    = BASE_W + 1 + IDX_W
) (
    input  logic [BASE_W-1:0] base,
    input  logic              is_fb,
    input  logic              is_bias,
    input  logic [IDX_W-1:0]  tag,
    output logic [AW-1:0]     addr,
    output logic              tag_ok
);
    localparam logic [IDX_W-1:0] BIAS_IDX = IDX_W'(NEIGH);

    logic [IDX_W-1:0] idx;

    always_comb begin
        idx    = is_bias ? BIAS_IDX : tag;
        addr   = {base, is_fb & ~is_bias, idx};
        tag_ok = (tag < BIAS_IDX);
    end
endmodule

// File: rtl/cnn_tpl_mem.sv
module cnn_tpl_mem #(
    parameter int DW = 8,
    parameter int AW = 11,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/cnn_disc_index.sv
module cnn_disc_index #(
    parameter int ACC_W  = 20,
    parameter int LUT_AW = 5,
    parameter int SHIFT  = 2
) (
    input  logic signed [ACC_W-1:0] state,
    output logic [LUT_AW-1:0]       idx
);
    localparam logic signed [ACC_W-1:0] HI = ACC_W'((1 << (LUT_AW - 1)) - 1);
    localparam logic signed [ACC_W-1:0] LO = -ACC_W'(1 << (LUT_AW - 1));

    logic signed [ACC_W-1:0] scaled;
    logic signed [ACC_W-1:0] clamped;

    always_comb begin
        scaled = state >>> SHIFT;
        if (scaled > HI) begin
            clamped = HI;
        end else if (scaled < LO) begin
            clamped = LO;
        end else begin
            clamped = scaled;
        end
        idx = {~clamped[LUT_AW-1], clamped[LUT_AW-2:0]};
    end
endmodule

// File: rtl/cnn_node_core.sv
module cnn_node_core
    import cnn_node_pkg::*;
#(
    parameter int DW     = 8,
    parameter int BASE_W = 6,
    parameter int IDX_W  = 4,
    parameter int NEIGH  = 9,
    parameter int ACC_W  = 20,
    parameter int SHIFT  = 2,
    parameter int IT_W   = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [BASE_W-1:0]      tpl_base,
    input  logic [IT_W-1:0]        n_iter,
    input  logic                   in_valid,
    input  logic [DW-1:0]          in_data,
    input  logic [IDX_W-1:0]       in_tag,
    output logic                   in_ready,
    input  logic                   wr_en,
    input  logic [BASE_W+IDX_W:0]  wr_addr,
    input  logic [DW-1:0]          wr_data,
    output logic [DW-1:0]          y_out,
    output logic                   done
);
    localparam int AW       = BASE_W + 1 + IDX_W;
    localparam int LUT_AW   = IDX_W + 1;
    localparam int CNT_W    = $clog2(NEIGH + 1);
    localparam int PW       = 2 * DW;
    localparam logic [BASE_W-1:0] LUT_BASE = {BASE_W{1'b1}};
    localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(NEIGH - 1);

    typedef struct packed {
        phase_e                  ph;
        logic [BASE_W-1:0]       base;
        logic [IT_W-1:0]         nit;
        logic [IT_W-1:0]         it;
        logic [CNT_W-1:0]        cnt;
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] cst;
        logic [DW-1:0]           y;
        logic                    done;
    } node_st_t;

    node_st_t r_q, r_d;

    logic [AW-1:0]           coef_addr;
    logic                    tag_ok;
    logic [DW-1:0]           coef_raw;
    logic [DW-1:0]           lut_word;
    logic [LUT_AW-1:0]       lut_idx;
    logic signed [DW-1:0]    coef_s;
    logic signed [DW-1:0]    data_s;
    logic signed [PW-1:0]    prod;
    logic signed [ACC_W-1:0] prod_ext;
    logic signed [ACC_W-1:0] coef_ext;
    logic                    take;

    cnn_coef_addr #(
        .BASE_W (BASE_W),
        .IDX_W  (IDX_W),
        .NEIGH  (NEIGH)
    ) u_addr (
        .base    (r_q.base),
        .is_fb   (r_q.ph == PH_YPASS),
        .is_bias (r_q.ph == PH_BIAS),
        .tag     (in_tag),
        .addr    (coef_addr),
        .tag_ok  (tag_ok)
    );

    cnn_disc_index #(
        .ACC_W  (ACC_W),
        .LUT_AW (LUT_AW),
        .SHIFT  (SHIFT)
    ) u_disc (
        .state (r_q.acc),
        .idx   (lut_idx)
    );

    cnn_tpl_mem #(
        .DW (DW),
        .AW (AW)
    ) u_mem (
        .clk     (clk),
        .we      (wr_en),
        .waddr   (wr_addr),
        .wdata   (wr_data),
        .raddr_a (coef_addr),
        .rdata_a (coef_raw),
        .raddr_b ({LUT_BASE, lut_idx}),
        .rdata_b (lut_word)
    );

    assign in_ready = (r_q.ph == PH_UPASS) || (r_q.ph == PH_YPASS);
    assign take     = in_valid && in_ready && tag_ok;
    assign coef_s   = coef_raw;
    assign data_s   = in_data;
    assign prod     = data_s * coef_s;
    assign prod_ext = {{(ACC_W - PW){prod[PW-1]}}, prod};
    assign coef_ext = {{(ACC_W - DW){coef_s[DW-1]}}, coef_s};

    always_comb begin
        r_d = r_q;
        case (r_q.ph)
            PH_IDLE: begin
                if (start) begin
                    r_d.ph   = PH_UPASS;
                    r_d.base = tpl_base;
                    r_d.nit  = n_iter;
                    r_d.it   = '0;
                    r_d.cnt  = '0;
                    r_d.acc  = '0;
                    r_d.done = 1'b0;
                end
            end
            PH_UPASS: begin
                if (take) begin
                    r_d.acc = r_q.acc + prod_ext;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == LAST_CNT) begin
                        r_d.ph = PH_BIAS;
                    end
                end
            end
            PH_BIAS: begin
                r_d.acc = r_q.acc + coef_ext;
                r_d.cst = r_q.acc + coef_ext;
                r_d.cnt = '0;
                r_d.ph  = (r_q.nit == '0) ? PH_DISC : PH_YPASS;
            end
            PH_YPASS: begin
                if (take) begin
                    r_d.acc = r_q.acc + prod_ext;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == LAST_CNT) begin
                        r_d.it = r_q.it + 1'b1;
                        r_d.ph = PH_DISC;
                    end
                end
            end
            PH_DISC: begin
                r_d.y = lut_word;
                if (r_q.it == r_q.nit) begin
                    r_d.done = 1'b1;
                    r_d.ph   = PH_IDLE;
                end else begin
                    r_d.acc = r_q.cst;
                    r_d.cnt = '0;
                    r_d.ph  = PH_YPASS;
                end
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign y_out = r_q.y;
    assign done  = r_q.done;
endmodule

// File: rtl/cnn_node_core_chk.sv
module cnn_node_core_chk
    import cnn_node_pkg::*;
#(
    parameter int DW     = 8,
    parameter int BASE_W = 6,
    parameter int NEIGH  = 9,
    localparam int CNT_W = $clog2(NEIGH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              in_ready,
    input logic              done,
    input logic [DW-1:0]     y_out,
    input phase_e            ph,
    input logic [CNT_W-1:0]  cnt,
    input logic [BASE_W-1:0] base
);
    // R1: accepting pairs and reporting completion never overlap
    a_r1_ready_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && done));

    // R3: the pair counter never passes the neighbourhood size
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(NEIGH));

    // R5: output only moves out of a discrimination step
    a_r5_y_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != PH_DISC) |=> $stable(y_out));

    // R6: done rises only right after a discrimination, and the core is idle then
    a_r6_done_after_disc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(ph == PH_DISC) && ph == PH_IDLE));

    // R8: start in a busy phase leaves the latched template base alone
    a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ph != PH_IDLE) |=> $stable(base));
endmodule

bind cnn_node_core cnn_node_core_chk #(
    .DW     (DW),
    .BASE_W (BASE_W),
    .NEIGH  (NEIGH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_ready (in_ready),
    .done     (done),
    .y_out    (y_out),
    .ph       (r_q.ph),
    .cnt      (r_q.cnt),
    .base     (r_q.base)
);

// File: tb/sim_cnn_node_core.sv
`timescale 1ns/1ps
module sim_cnn_node_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  tpl_base = '0;
    logic [7:0]  n_iter = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic [3:0]  in_tag = '0;
    logic        in_ready;
    logic        wr_en = 1'b0;
    logic [10:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  y_out;
    logic        done;

    int errors = 0;
    int checks = 0;
    logic signed [7:0] tm [0:2047];

    always #2.5 clk = ~clk;

    cnn_node_core u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .tpl_base(tpl_base),
        .n_iter(n_iter), .in_valid(in_valid), .in_data(in_data),
        .in_tag(in_tag), .in_ready(in_ready), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .y_out(y_out), .done(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int caddr(input int base, input int fb, input int idx);
        return base * 32 + fb * 16 + idx;
    endfunction

    function automatic int lut_addr(input int st);
        int s;
        s = st >>> 2;
        if (s > 15) s = 15;
        if (s < -16) s = -16;
        return 63 * 32 + s + 16;
    endfunction

    function automatic int rnd(input int amp);
        return int'($urandom_range(2 * amp - 1)) - amp;
    endfunction

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 11'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
        tm[addr] = 8'(data);
    endtask

    task automatic fill(input int base, input int amp, input int fixc);
        for (int i = 0; i < 10; i++) wr(caddr(base, 0, i), fixc != 0 ? fixc : rnd(amp));
        for (int i = 0; i < 9; i++) wr(caddr(base, 1, i), fixc != 0 ? fixc : rnd(amp));
    endtask

    task automatic send(input int val, input int tag, input bit w, input int wa, input int wd);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_data = 8'(val); in_tag = 4'(tag);
        if (w) begin
            wr_en = 1'b1; wr_addr = 11'(wa); wr_data = 8'(wd);
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0; wr_en = 1'b0;
    endtask

    task automatic run(input int base, input int nit, input int amp, input int fixv,
                       input bit collide, input bit junk, input bit busy, input string req);
        int perm [9];
        int st, cst, v, t, j, exp_y, na;
        @(negedge clk);
        start = 1'b1; tpl_base = 6'(base); n_iter = 8'(nit);
        @(posedge clk);
        #1 start = 1'b0;
        chk("R6 done cleared by start", int'(done), 0);
        for (int i = 0; i < 9; i++) perm[i] = i;
        for (int i = 8; i > 0; i--) begin
            j = int'($urandom_range(i)); t = perm[i]; perm[i] = perm[j]; perm[j] = t;
        end
        cst = 0;
        for (int k = 0; k < 9; k++) begin
            v = (fixv != 0) ? fixv : rnd(amp);
            cst += v * int'(tm[caddr(base, 0, perm[k])]);
            if (junk && k == 3) send(rnd(128), 9 + int'($urandom_range(6)), 1'b0, 0, 0);
            if (busy && k == 2) begin
                @(negedge clk);
                start = 1'b1; tpl_base = 6'(base ^ 1); n_iter = 8'(nit + 2);
                @(posedge clk);
                #1 start = 1'b0;
            end
            if (collide && k == 5) begin
                na = rnd(64);
                send(v, perm[k], 1'b1, caddr(base, 0, perm[k]), na);
                tm[caddr(base, 0, perm[k])] = 8'(na);
            end else begin
                send(v, perm[k], 1'b0, 0, 0);
            end
        end
        cst += int'(tm[caddr(base, 0, 9)]);
        exp_y = int'(tm[lut_addr(cst)]);
        for (int it = 0; it < nit; it++) begin
            st = cst;
            for (int k = 0; k < 9; k++) begin
                v = (fixv != 0) ? fixv : rnd(amp);
                st += v * int'(tm[caddr(base, 1, perm[k])]);
                if (junk && k == 6) send(rnd(128), 9 + int'($urandom_range(6)), 1'b0, 0, 0);
                send(v, perm[k], 1'b0, 0, 0);
            end
            exp_y = int'(tm[lut_addr(st)]);
        end
        @(negedge clk);
        while (!done) @(negedge clk);
        chk(req, int'($signed(y_out)), exp_y);
        repeat (3) @(negedge clk);
        chk("R6 done held", int'(done), 1);
        chk("R5 output held after done", int'($signed(y_out)), exp_y);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 2048; i++) tm[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1 y_out reset", int'(y_out), 0);
        chk("R1 done reset", int'(done), 0);
        chk("R1 in_ready reset", int'(in_ready), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 32; i++) wr(63 * 32 + i, rnd(128));
        for (int b = 0; b < 4; b++) fill(b, 4, 0);
        fill(5, 0, 127);
        // R2 R3: single-pass constant through the address scheme
        run(0, 0, 4, 0, 1'b0, 1'b0, 1'b0, "R2 R3 constant pass");
        run(2, 0, 4, 0, 1'b0, 1'b0, 1'b0, "R2 R3 constant pass base2");
        // R4: several iterations reuse the stored constant
        run(1, 3, 4, 0, 1'b0, 1'b0, 1'b0, "R4 R6 three iterations");
        run(3, 1, 4, 0, 1'b0, 1'b0, 1'b0, "R4 R6 one iteration");
        // R7: out-of-range tags ignored
        run(2, 2, 4, 0, 1'b0, 1'b1, 1'b0, "R7 ignored tags");
        // R8: start while busy
        run(0, 1, 4, 0, 1'b0, 1'b0, 1'b1, "R8 start while busy");
        // R9: write colliding with the coefficient read, then the new value used
        run(1, 0, 4, 0, 1'b1, 1'b0, 1'b0, "R9 old coefficient on collision");
        run(1, 0, 4, 0, 1'b0, 1'b0, 1'b0, "R9 new coefficient afterwards");
        // R10: saturation at both table ends
        run(5, 0, 0, 127, 1'b0, 1'b0, 1'b0, "R10 clamp high");
        chk("R10 top table word", int'($signed(y_out)), int'(tm[63 * 32 + 31]));
        run(5, 1, 0, -128, 1'b0, 1'b0, 1'b0, "R10 clamp low");
        chk("R10 bottom table word", int'($signed(y_out)), int'(tm[63 * 32]));
        // random mix
        for (int n = 0; n < 12; n++) begin
            run(int'($urandom_range(3)), int'($urandom_range(3)), 2 + int'($urandom_range(6)), 0,
                1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)),
                "R3 R4 R5 random run");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule